// File: doc/BRIEF.md
# Request-Grant-Accept Crossbar Scheduler

This block picks, once per cell time, which inputs of an input-queued crossbar connect to which outputs. Every input keeps one queue per output. A flag vector tells the scheduler which of those queues hold at least one cell. From that snapshot the block runs a fixed number of matching rounds, one per clock. In each round the inputs that are still free raise a one-bit request towards every free output they have traffic for. Each free output grants exactly one requester. Each input that received grants accepts exactly one of them. A pair formed in one round takes no part in the rounds after it.

The grant and accept choices rotate by round-robin pointers. One pointer sits at each output and one at each input. A pointer moves only when a grant is accepted in the first round, and it then points one place past the port that was chosen. Under heavy load this makes the outputs fan out over different inputs.

After the last round the block presents a permutation matrix with a valid flag. The matrix has at most one bit per row and per column. It holds until the next start is taken.

Top module: `xbar_rga_sched`

## Requirements
- R1: A start pulse taken while idle captures `voq_nempty_i`, where bit i*N_PORTS+j set means input i holds a cell for output j. A bit of `match_o` (same indexing) is set only where the captured snapshot had that bit set.
- R2: `match_valid_o` drops on the clock edge that takes a start. It rises exactly N_ITER edges later. It then stays high, with `match_o` unchanged, until the next start is taken.
- R3: `match_o` has at most one bit set in every row (input) and every column (output), and an unmatched port has an all-zero row or column.
- R4: In each round, every unmatched output grants the first unmatched requesting input found by scanning upward in circular order from its grant pointer.
- R5: Every unmatched input accepts the first granting output found by scanning upward in circular order from its accept pointer.
- R6: All pointers are zero after reset. A pointer changes only when a grant is accepted in the first round of a computation, and it then takes the value one past the chosen port, wrapping to 0 after N_PORTS-1.
- R7: A port matched in an earlier round neither requests nor grants in later rounds, so with all queues full and reset pointers, three rounds pair input k with output k for k = 0, 1, 2 only.
- R8: A start pulse that arrives while a computation is running is ignored, together with the flags that come with it.
- R9: During and after reset `match_valid_o` is 0 and `match_o` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Begin a new computation from the current queue flags |
| voq_nempty_i | input | N_PORTS*N_PORTS | Queue non-empty flags, bit i*N_PORTS+j for input i to output j |
| match_o | output | N_PORTS*N_PORTS | Match matrix, bit i*N_PORTS+j set when input i is connected to output j |
| match_valid_o | output | 1 | The match matrix is final |

## Verification
The hardest case to reach is pointer state that has drifted away from reset. Only that state shows whether the rotation rules hold, because with zero pointers every output favours input 0 and many faults are hidden. The bench reaches this state by running many back-to-back computations without a reset in between: several fully loaded cells, a sweep of every single request bit, and random occupancy at varied densities. All of these run against a bench model that carries its own pointer copies. A start pulse is also injected in the middle of a computation, with a different snapshot, to show it is ignored.

// File: rtl/xrs_pkg.sv
package xrs_pkg;

  // Circular increment of a port index over n ports.
  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/xrs_rr_pick.sv
// Combinational round-robin pick: first set request at or after ptr_i.
module xrs_rr_pick #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned PW    = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] req_i,
  input  logic [PW-1:0]    ptr_i,
  output logic [WIDTH-1:0] pick_oh_o,
  output logic [PW-1:0]    pick_idx_o
);

  always_comb begin
    logic found;
    found      = 1'b0;
    pick_oh_o  = '0;
    pick_idx_o = '0;
    for (int unsigned k = 0; k < WIDTH; k++) begin
      int unsigned pos;
      pos = (int'(ptr_i) + k) % WIDTH;
      if (!found && req_i[pos]) begin
        found          = 1'b1;
        pick_oh_o[pos] = 1'b1;
        pick_idx_o     = PW'(pos);
      end
    end
  end

endmodule

// File: rtl/xrs_rr_ptr.sv
// Round-robin pointer: on enable, moves one past the chosen port.
module xrs_rr_ptr
  import xrs_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned PW    = $clog2(WIDTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic [PW-1:0] chosen_i,
  output logic [PW-1:0] ptr_o
);

  logic [PW-1:0] ptr_q, ptr_n;

  always_comb begin
    ptr_n = PW'(wrap_inc(int'(chosen_i), WIDTH));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (en_i) begin
      ptr_q <= ptr_n;
    end
  end

  assign ptr_o = ptr_q;

endmodule

// File: rtl/xbar_rga_sched.sv
module xbar_rga_sched #(
  parameter int unsigned N_PORTS = 8,
  parameter int unsigned N_ITER  = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic [N_PORTS*N_PORTS-1:0]   voq_nempty_i,
  output logic [N_PORTS*N_PORTS-1:0]   match_o,
  output logic                         match_valid_o
);

  localparam int unsigned N    = N_PORTS;
  localparam int unsigned NN   = N_PORTS * N_PORTS;
  localparam int unsigned PW   = $clog2(N_PORTS);
  localparam int unsigned IW   = (N_ITER > 1) ? $clog2(N_ITER) : 1;
  localparam int unsigned LAST = N_ITER - 1;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= '0;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rsync_q[1];

  // State
  logic          busy_q, busy_n;
  logic [IW-1:0] iter_q, iter_n;
  logic [NN-1:0] req_q, req_n;
  logic [N-1:0]  in_done_q, in_done_n;
  logic [N-1:0]  out_done_q, out_done_n;
  logic [NN-1:0] match_q, match_n;
  logic          valid_q, valid_n;

  // Per-round exchange
  logic [NN-1:0] gnt_m;
  logic [NN-1:0] acc_m;
  logic [N-1:0]  in_acc;
  logic [N-1:0]  out_acc;
  logic          first_iter;
  logic          start_take;
  logic          upd_en;

  assign first_iter = busy_q && (iter_q == '0);
  assign start_take = start_i && !busy_q;
  assign upd_en     = start_take || busy_q;

  // Output side: grant one requester per free output.
  for (genvar j = 0; j < N; j++) begin : g_out
    logic [N-1:0]  g_req;
    logic [N-1:0]  g_oh;
    logic [PW-1:0] g_idx;
    logic [PW-1:0] g_ptr;
    logic [N-1:0]  col_acc;

    for (genvar i = 0; i < N; i++) begin : g_col
      assign g_req[i]       = busy_q && req_q[i*N+j] && !in_done_q[i] && !out_done_q[j];
      assign gnt_m[i*N+j]   = g_oh[i];
      assign col_acc[i]     = acc_m[i*N+j];
    end

    assign out_acc[j] = |col_acc;

    xrs_rr_pick #(.WIDTH(N), .PW(PW)) u_gpick (
      .req_i      (g_req),
      .ptr_i      (g_ptr),
      .pick_oh_o  (g_oh),
      .pick_idx_o (g_idx)
    );

    xrs_rr_ptr #(.WIDTH(N), .PW(PW)) u_gptr (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .en_i     (first_iter && out_acc[j]),
      .chosen_i (g_idx),
      .ptr_o    (g_ptr)
    );
  end

  // Input side: accept one grant per input.
  for (genvar i = 0; i < N; i++) begin : g_in
    logic [N-1:0]  a_req;
    logic [N-1:0]  a_oh;
    logic [PW-1:0] a_idx;
    logic [PW-1:0] a_ptr;

    assign a_req                = gnt_m[i*N +: N];
    assign acc_m[i*N +: N]      = a_oh;
    assign in_acc[i]            = |a_oh;

    xrs_rr_pick #(.WIDTH(N), .PW(PW)) u_apick (
      .req_i      (a_req),
      .ptr_i      (a_ptr),
      .pick_oh_o  (a_oh),
      .pick_idx_o (a_idx)
    );

    xrs_rr_ptr #(.WIDTH(N), .PW(PW)) u_aptr (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .en_i     (first_iter && in_acc[i]),
      .chosen_i (a_idx),
      .ptr_o    (a_ptr)
    );
  end

  // Next state
  always_comb begin
    busy_n     = busy_q;
    iter_n     = iter_q;
    req_n      = req_q;
    in_done_n  = in_done_q;
    out_done_n = out_done_q;
    match_n    = match_q;
    valid_n    = valid_q;
    if (start_take) begin
      busy_n     = 1'b1;
      iter_n     = '0;
      req_n      = voq_nempty_i;
      in_done_n  = '0;
      out_done_n = '0;
      match_n    = '0;
      valid_n    = 1'b0;
    end else if (busy_q) begin
      match_n    = match_q | acc_m;
      in_done_n  = in_done_q | in_acc;
      out_done_n = out_done_q | out_acc;
      if (iter_q == IW'(LAST)) begin
        busy_n  = 1'b0;
        valid_n = 1'b1;
        iter_n  = '0;
      end else begin
        iter_n = iter_q + 1'b1;
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      busy_q     <= 1'b0;
      iter_q     <= '0;
      req_q      <= '0;
      in_done_q  <= '0;
      out_done_q <= '0;
      match_q    <= '0;
      valid_q    <= 1'b0;
    end else if (upd_en) begin
      busy_q     <= busy_n;
      iter_q     <= iter_n;
      req_q      <= req_n;
      in_done_q  <= in_done_n;
      out_done_q <= out_done_n;
      match_q    <= match_n;
      valid_q    <= valid_n;
    end
  end

  assign match_o       = match_q;
  assign match_valid_o = valid_q;

endmodule

// File: rtl/xbar_rga_sched_chk.sv
module xbar_rga_sched_chk #(
  parameter int unsigned N_PORTS = 8,
  parameter int unsigned N_ITER  = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       start_i,
  input logic [N_PORTS*N_PORTS-1:0] voq_nempty_i,
  input logic [N_PORTS*N_PORTS-1:0] match_o,
  input logic                       match_valid_o
);

  localparam int unsigned N  = N_PORTS;
  localparam int unsigned NN = N_PORTS * N_PORTS;
  localparam int unsigned CW = $clog2(N_ITER + 1);

  // Own count of cycles since a start was taken (0 = idle).
  logic [CW-1:0] cnt_q;
  logic [NN-1:0] snap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      snap_q <= '0;
    end else if (cnt_q == '0) begin
      if (start_i) begin
        cnt_q  <= CW'(1);
        snap_q <= voq_nempty_i;
      end
    end else begin
      cnt_q <= (cnt_q == CW'(N_ITER)) ? '0 : cnt_q + 1'b1;
    end
  end

  AST_VALID_AFTER_ROUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(N_ITER)) |=> match_valid_o);  // R2

  AST_NO_EARLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> !match_valid_o);  // R2

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (match_valid_o && !start_i) |=> (match_valid_o && $stable(match_o)));  // R2

  AST_ONLY_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
    match_valid_o |-> ((match_o & ~snap_q) == '0));  // R1 R8

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !match_valid_o) |-> (match_o == '0));  // R9

  for (genvar k = 0; k < N; k++) begin : g_perm
    logic [N-1:0] col;
    for (genvar r = 0; r < N; r++) begin : g_c
      assign col[r] = match_o[r*N+k];
    end
    AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match_o[k*N +: N]));  // R3
    AST_COL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col));  // R3
  end

endmodule

bind xbar_rga_sched xbar_rga_sched_chk #(.N_PORTS(N_PORTS), .N_ITER(N_ITER)) u_chk (
  .clk           (clk),
  .rst_n         (rst_int_n),
  .start_i       (start_i),
  .voq_nempty_i  (voq_nempty_i),
  .match_o       (match_o),
  .match_valid_o (match_valid_o)
);

// File: tb/xbar_rga_sched_bench.sv
module xbar_rga_sched_bench;

  localparam int N          = 8;
  localparam int IT         = 3;
  localparam int NN         = N * N;
  localparam int CLK_PERIOD = 10;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [NN-1:0] voq;
  logic [NN-1:0] match;
  logic          valid;

  int n_chk;
  int n_bad;
  bit done;

  // Bench copies of the round-robin pointers (R6: zero after reset).
  int gp [N];
  int ap [N];

  xbar_rga_sched #(.N_PORTS(N), .N_ITER(IT)) u_xbar_rga_sched (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start),
    .voq_nempty_i  (voq),
    .match_o       (match),
    .match_valid_o (valid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [NN-1:0] act, input logic [NN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit perm_ok(input logic [NN-1:0] m);
    for (int a = 0; a < N; a++) begin
      int rc, cc;
      rc = 0; cc = 0;
      for (int b = 0; b < N; b++) begin
        rc += int'(m[a*N+b]);
        cc += int'(m[b*N+a]);
      end
      if (rc > 1 || cc > 1) return 1'b0;
    end
    return 1'b1;
  endfunction

  // Request / grant / accept rounds computed from the requirements.
  task automatic model(input logic [NN-1:0] v, output logic [NN-1:0] m);
    bit in_m [N];
    bit out_m [N];
    int gnt [N];
    m = '0;
    for (int a = 0; a < N; a++) begin in_m[a] = 0; out_m[a] = 0; end
    for (int it = 0; it < IT; it++) begin
      for (int j = 0; j < N; j++) begin
        gnt[j] = -1;
        if (!out_m[j]) begin
          for (int k = 0; k < N; k++) begin
            int i;
            i = (gp[j] + k) % N;
            if (gnt[j] < 0 && !in_m[i] && v[i*N+j]) gnt[j] = i;
          end
        end
      end
      for (int i = 0; i < N; i++) begin
        if (!in_m[i]) begin
          int pick;
          pick = -1;
          for (int k = 0; k < N; k++) begin
            int j;
            j = (ap[i] + k) % N;
            if (pick < 0 && gnt[j] == i) pick = j;
          end
          if (pick >= 0) begin
            m[i*N+pick] = 1'b1;
            in_m[i]     = 1;
            out_m[pick] = 1;
            if (it == 0) begin
              ap[i]    = (pick + 1) % N;
              gp[pick] = (i + 1) % N;
            end
          end
        end
      end
    end
  endtask

  // One cell time; optionally pokes a second start mid-computation.
  task automatic run_cell(input logic [NN-1:0] v, input bit poke,
                          input logic [NN-1:0] pv, input string tag,
                          output logic [NN-1:0] got);
    logic [NN-1:0] exp;
    model(v, exp);
    @(negedge clk);
    start = 1'b1;
    voq   = v;
    @(negedge clk);
    chk("R2 valid low after start", NN'(valid), NN'(0));
    if (poke) begin
      start = 1'b1;
      voq   = pv;
    end else begin
      start = 1'b0;
    end
    for (int k = 1; k <= IT; k++) begin
      @(negedge clk);
      start = 1'b0;
      if (k < IT) chk("R2 no early valid", NN'(valid), NN'(0));
      else        chk("R2 valid after rounds", NN'(valid), NN'(1));
    end
    chk(tag, match, exp);
    chk("R3 one per row and column", NN'(perm_ok(match)), NN'(1));
    got = match;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [NN-1:0] got;
    logic [NN-1:0] dir;
    logic [NN-1:0] full;
    n_chk = 0;
    n_bad = 0;
    done  = 0;
    full  = '1;
    for (int a = 0; a < N; a++) begin gp[a] = 0; ap[a] = 0; end
    rst_n = 1'b0;
    start = 1'b0;
    voq   = '0;
    repeat (3) @(negedge clk);
    chk("R9 valid in reset", NN'(valid), NN'(0));
    chk("R9 match in reset", match, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 valid after reset", NN'(valid), NN'(0));
    chk("R9 match after reset", match, '0);

    // R4 R7: full load, zero pointers -> diagonal on ports 0..2.
    run_cell(full, 0, '0, "R4 R7 model full", got);
    dir = '0;
    for (int k = 0; k < IT; k++) dir[k*N+k] = 1'b1;
    chk("R7 R4 directed full load", got, dir);

    // R5 R6: second full cell after pointer moves on port 0 only.
    run_cell(full, 0, '0, "R5 R6 model full", got);
    dir = '0;
    dir[0*N+1] = 1'b1;
    dir[1*N+0] = 1'b1;
    dir[2*N+2] = 1'b1;
    dir[3*N+3] = 1'b1;
    chk("R5 R6 directed second cell", got, dir);

    // R2: result held while no start arrives.
    repeat (6) @(negedge clk);
    chk("R2 hold valid", NN'(valid), NN'(1));
    chk("R2 hold match", match, dir);

    // R1: empty snapshot gives an empty match.
    run_cell('0, 0, '0, "R1 empty", got);
    chk("R1 empty directed", got, '0);

    // R1 R4: every single request bit on its own.
    for (int b = 0; b < NN; b++) begin
      logic [NN-1:0] one;
      one    = '0;
      one[b] = 1'b1;
      run_cell(one, 0, '0, "R1 R4 single request model", got);
      chk("R1 single request directed", got, one);
    end

    // R6 R4 R5: sustained full load drives the pointers apart.
    for (int c = 0; c < 12; c++) run_cell(full, 0, '0, "R4 R5 R6 full load", got);

    // R8: a start during a computation is ignored with its flags.
    for (int c = 0; c < 8; c++) begin
      logic [NN-1:0] v;
      for (int b = 0; b < NN; b++) v[b] = ($urandom_range(0, 99) < 40);
      run_cell(v, 1, ~v, "R8 start while busy ignored", got);
    end

    // R1 R4 R5 R6 R7: random occupancy at several densities.
    for (int c = 0; c < 400; c++) begin
      logic [NN-1:0] v;
      int dens;
      dens = 5 + (c % 8) * 12;
      for (int b = 0; b < NN; b++) v[b] = ($urandom_range(0, 99) < dens);
      run_cell(v, 0, '0, "R1 R4 R5 R6 R7 random", got);
    end

    done = 1;
    summary();
    $finish;
  end

endmodule